// File: doc/BRIEF.md
# Reference Divider with Comparison Tap Select

This block turns a reference clock into the comparison events of a dual-loop frequency synthesizer. A programmable counter divides the reference by a ratio between 4 and 4095. A three-stage binary post-scaler follows it and offers the divided rate at divide-by-1, 2, 4 and 8. The main loop and the auxiliary loop each pick one of these four taps with their own 2-bit code. Every event leaves the block as a pulse one reference cycle wide.

Around each main comparison pulse the block also raises a compensation window. The window opens one reference cycle before the pulse and closes one cycle after it, so a fractional-compensation current can be gated symmetrically. A test output carries the undivided-tap event, which shows the raw divider rate. The divider runs while either loop is enabled and is held cleared while both are off.

Top module: `ref_tap_divider`

## Requirements
- R1: After a synchronous active-low reset, `main_pulse`, `aux_pulse`, `comp_window` and `ref_tick` are all low.
- R2: With a ratio R between 4 and 4095, `ref_tick` rests low and goes high for exactly one cycle in every R cycles.
- R3: A ratio below 4 (0 to 3) divides by 4.
- R4: `main_sel` code k (0 to 3) makes `main_pulse` fire for one cycle once every R·2^k cycles.
- R5: `aux_sel` uses the reversed order: code k makes `aux_pulse` fire once every R·2^(3-k) cycles, so code 0 is the slowest tap and code 3 is the fastest.
- R6: While `main_en` and `aux_en` are both low, the divider and the post-scaler are held at zero and no pulse is issued. When an enable rises at a clock edge, the first `ref_tick` is high in the cycle that follows the (R+1)-th rising edge counted from that edge.
- R7: `main_pulse` fires only while `main_en` is high, and `aux_pulse` only while `aux_en` is high. Either enable alone keeps the divider running.
- R8: `comp_window` is high in the cycle before a main pulse, in the cycle of the pulse and in the cycle after it, and low at all other times.
- R9: Every selected pulse coincides with a `ref_tick` pulse, because all taps share one event alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio | input | 12 | Programmable divide ratio |
| main_sel | input | 2 | Main loop tap code |
| aux_sel | input | 2 | Auxiliary loop tap code (reversed order) |
| main_en | input | 1 | Main loop enable |
| aux_en | input | 1 | Auxiliary loop enable |
| main_pulse | output | 1 | Main comparison pulse |
| aux_pulse | output | 1 | Auxiliary comparison pulse |
| comp_window | output | 1 | Compensation window around the main pulse |
| ref_tick | output | 1 | Test output of the divided reference |

## Verification
The bench builds the block with its default parameters: a 12-bit ratio and three post-scaler stages. These give both the full ratio range, up to 4095, and all four tap codes on both selects. With the small ratios 2 and 5, every tap period up to R·8 fits in a few dozen cycles, so each select code and the clamp are checked over several periods. A single run at ratio 4095 covers the top of the counter.

// File: rtl/ref_div_pkg.sv
// Shared constants for the reference tap divider.
// Assumes: the post-scaler stage count stays small (a handful of taps).
package ref_div_pkg;
    localparam int unsigned RATIO_W_DEF   = 12;
    localparam int unsigned STAGES_DEF    = 3;
    localparam int unsigned MIN_RATIO_DEF = 4;
endpackage

// File: rtl/ref_ratio_counter.sv
// Programmable divide-by-R counter. Emits a one-cycle terminal tick every
// max(R, MIN_RATIO) cycles while active; held at zero while inactive.
// Assumes: ratio may change at any time; a count already past the new
// terminal value wraps at once.
module ref_ratio_counter #(
    parameter int unsigned RATIO_W   = ref_div_pkg::RATIO_W_DEF,
    parameter int unsigned MIN_RATIO = ref_div_pkg::MIN_RATIO_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);

    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] last_val;

    // Terminal value after clamping small ratios
    always_comb begin
        last_val = ((ratio < MIN_R) ? MIN_R : ratio) - RATIO_W'(1);
        tick     = active && (cnt >= last_val);
    end

    // Count up, wrap at terminal, hold cleared while inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt <= '0;
        else if (tick)         cnt <= '0;
        else                   cnt <= cnt + RATIO_W'(1);
    end

    // R2
    tc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0));
endmodule

// File: rtl/ref_post_scaler.sv
// Binary post-scaler after the ratio counter. Tap k is high on the ticks
// that complete a group of 2^k ticks; tap 0 is every tick.
// Assumes: tick is a single-cycle strobe.
module ref_post_scaler #(
    parameter int unsigned STAGES = ref_div_pkg::STAGES_DEF,
    localparam int unsigned TAPS  = STAGES + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            tick,
    output logic [TAPS-1:0] taps
);
    logic [STAGES-1:0] post;

    // Advance the binary count on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !active) post <= '0;
        else if (tick)         post <= post + STAGES'(1);
    end

    assign taps[0] = tick;
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        // Tap k fires when the low k bits are all ones at a tick
        assign taps[k] = tick && (&post[k-1:0]);
        // R4
        nested_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            taps[k] |-> taps[k-1]);
    end

    // R4
    post_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active) |=> (post == $past(post) + STAGES'(1)));
endmodule

// File: rtl/ref_tap_pick.sv
// Selects one tap and delivers it through a two-register pipeline:
// 'early' leads 'pulse' by one cycle, which the window logic relies on.
// Assumes: REVERSE=1 maps code k to tap TAPS-1-k.
module ref_tap_pick #(
    parameter int unsigned TAPS    = ref_div_pkg::STAGES_DEF + 1,
    parameter bit          REVERSE = 1'b0,
    localparam int unsigned SEL_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAPS-1:0]  taps,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic             early,
    output logic             pulse
);
    logic [SEL_W-1:0] idx;
    logic             hit;

    // Map the code onto a tap index, in forward or reversed order
    always_comb begin
        idx = REVERSE ? (SEL_W'(TAPS - 1) - sel) : sel;
        hit = (int'(idx) < TAPS) ? taps[idx] : 1'b0;
    end

    // Register the selected event, then align it to the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early <= 1'b0;
            pulse <= 1'b0;
        end else begin
            early <= hit && en;
            pulse <= early;
        end
    end

    // R4 R5
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/ref_tap_divider.sv
// Top: reference divider, binary post-scaler, main/aux tap selects,
// compensation window and divided-reference test output.
// Assumes: one reference-clock domain; ratio and selects are quasi-static.
module ref_tap_divider #(
    parameter int unsigned RATIO_W   = ref_div_pkg::RATIO_W_DEF,
    parameter int unsigned STAGES    = ref_div_pkg::STAGES_DEF,
    parameter int unsigned MIN_RATIO = ref_div_pkg::MIN_RATIO_DEF,
    localparam int unsigned TAPS     = STAGES + 1,
    localparam int unsigned SEL_W    = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [SEL_W-1:0]   main_sel,
    input  logic [SEL_W-1:0]   aux_sel,
    input  logic               main_en,
    input  logic               aux_en,
    output logic               main_pulse,
    output logic               aux_pulse,
    output logic               comp_window,
    output logic               ref_tick
);
    logic            active;
    logic            div_tick;
    logic [TAPS-1:0] taps;
    logic            main_early, aux_early, tick_early;
    logic            main_after;

    assign active = main_en || aux_en;

    ref_ratio_counter #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_cnt (
        .clk(clk), .rst_n(rst_n), .active(active), .ratio(ratio), .tick(div_tick)
    );

    ref_post_scaler #(.STAGES(STAGES)) u_post (
        .clk(clk), .rst_n(rst_n), .active(active), .tick(div_tick), .taps(taps)
    );

    ref_tap_pick #(.TAPS(TAPS), .REVERSE(1'b0)) u_main (
        .clk(clk), .rst_n(rst_n), .taps(taps), .sel(main_sel), .en(main_en),
        .early(main_early), .pulse(main_pulse)
    );

    ref_tap_pick #(.TAPS(TAPS), .REVERSE(1'b1)) u_aux (
        .clk(clk), .rst_n(rst_n), .taps(taps), .sel(aux_sel), .en(aux_en),
        .early(aux_early), .pulse(aux_pulse)
    );

    ref_tap_pick #(.TAPS(TAPS), .REVERSE(1'b0)) u_test (
        .clk(clk), .rst_n(rst_n), .taps(taps), .sel('0), .en(1'b1),
        .early(tick_early), .pulse(ref_tick)
    );

    // Hold the main event one more cycle for the trailing window edge
    always_ff @(posedge clk) begin
        if (!rst_n) main_after <= 1'b0;
        else        main_after <= main_pulse;
    end

    assign comp_window = main_early || main_pulse || main_after;

    // R9
    tap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_pulse || aux_pulse) |-> ref_tick);
    // R8
    window_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_pulse |=> comp_window);
    // R7
    main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_pulse |-> $past(main_en, 2));
endmodule

// File: tb/ref_tap_divider_bench.sv
`timescale 1ns/1ps
module ref_tap_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ratio = 12'd5;
    logic [1:0]  main_sel = 2'd0;
    logic [1:0]  aux_sel = 2'd0;
    logic        main_en = 1'b0;
    logic        aux_en = 1'b0;
    logic        main_pulse, aux_pulse, comp_window, ref_tick;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    ref_tap_divider u_ref_tap_divider (
        .clk(clk), .rst_n(rst_n), .ratio(ratio), .main_sel(main_sel),
        .aux_sel(aux_sel), .main_en(main_en), .aux_en(aux_en),
        .main_pulse(main_pulse), .aux_pulse(aux_pulse),
        .comp_window(comp_window), .ref_tick(ref_tick)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, evaluated at each rising edge
    int m_cnt = 0, m_post = 0;
    bit m_pre_main = 0, m_pre_aux = 0, m_pre_tick = 0;
    bit e_main = 0, e_aux = 0, e_tick = 0, e_after = 0;

    always @(posedge clk) begin
        int eff;
        bit act, tc;
        if (!rst_n) begin
            m_cnt <= 0; m_post <= 0;
            m_pre_main <= 0; m_pre_aux <= 0; m_pre_tick <= 0;
            e_main <= 0; e_aux <= 0; e_tick <= 0; e_after <= 0;
        end else begin
            act = main_en || aux_en;
            eff = (ratio < 4) ? 4 : int'(ratio);
            tc  = act && (m_cnt >= eff - 1);
            e_after    <= e_main;
            e_main     <= m_pre_main;
            e_aux      <= m_pre_aux;
            e_tick     <= m_pre_tick;
            m_pre_tick <= tc;
            m_pre_main <= tc && main_en && ((m_post % (1 << main_sel)) == (1 << main_sel) - 1);
            m_pre_aux  <= tc && aux_en && ((m_post % (1 << (3 - aux_sel))) == (1 << (3 - aux_sel)) - 1);
            m_cnt  <= (!act || tc) ? 0 : m_cnt + 1;
            m_post <= !act ? 0 : (tc ? (m_post + 1) % 8 : m_post);
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 ref_tick",    int'(ref_tick),    int'(e_tick));
            chk("R4 main_pulse",  int'(main_pulse),  int'(e_main));
            chk("R5 aux_pulse",   int'(aux_pulse),   int'(e_aux));
            chk("R8 comp_window", int'(comp_window), int'(m_pre_main || e_main || e_after));
            chk("R9 alignment",   int'((main_pulse || aux_pulse) && !ref_tick), 0);
        end
    end

    // Gap between the 2nd and 3rd pulses of the chosen output (0 main, 1 aux, 2 tick)
    task automatic gap(input int which, output int period);
        int seen = 0, n = 0, last = 0;
        bit v;
        period = -1;
        for (int i = 0; i < 70000 && seen < 3; i++) begin
            @(negedge clk);
            n++;
            v = (which == 0) ? main_pulse : (which == 1) ? aux_pulse : ref_tick;
            if (v) begin
                seen++;
                if (seen == 3) period = n - last;
                last = n;
            end
        end
    endtask

    task automatic count_hi(input int cycles, output int mp, output int ap, output int wn);
        mp = 0; ap = 0; wn = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            mp += int'(main_pulse); ap += int'(aux_pulse); wn += int'(comp_window);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int p, mp, ap, wn, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 main_pulse", int'(main_pulse), 0);
        chk("R1 aux_pulse", int'(aux_pulse), 0);
        chk("R1 comp_window", int'(comp_window), 0);
        chk("R1 ref_tick", int'(ref_tick), 0);
        cmp_on = 1'b1;

        // R6 idle: nothing moves with both enables low
        count_hi(30, mp, ap, wn);
        chk("R6 idle pulses", mp + ap + wn, 0);

        // R6 first tick latency after enable
        main_en = 1'b1;
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            n++;
            if (ref_tick) break;
        end
        chk("R6 first tick latency", n, 6);

        gap(2, p); chk("R2 tick period R=5", p, 5);
        for (int k = 0; k < 4; k++) begin
            main_sel = 2'(k);
            gap(0, p); chk($sformatf("R4 main period code %0d", k), p, 5 << k);
        end

        aux_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            aux_sel = 2'(k);
            gap(1, p); chk($sformatf("R5 aux period code %0d", k), p, 5 << (3 - k));
        end

        // R3 clamp
        main_sel = 2'd0;
        ratio = 12'd2; gap(2, p); chk("R3 ratio 2 clamps", p, 4);
        ratio = 12'd0; gap(2, p); chk("R3 ratio 0 clamps", p, 4);
        ratio = 12'd4; gap(0, p); chk("R3 ratio 4 main", p, 4);

        // R7 gating per loop
        ratio = 12'd5; aux_sel = 2'd3;
        main_en = 1'b0;
        repeat (3) @(negedge clk);
        count_hi(100, mp, ap, wn);
        chk("R7 main off pulses", mp, 0);
        chk("R8 window off", wn, 0);
        chk("R7 aux keeps running", ap, 20);
        main_en = 1'b1; aux_en = 1'b0;
        repeat (3) @(negedge clk);
        count_hi(100, mp, ap, wn);
        chk("R7 aux off pulses", ap, 0);
        chk("R8 window cycles", wn, 60);

        // R2 top of range
        ratio = 12'd4095;
        gap(2, p); chk("R2 tick period R=4095", p, 4095);

        main_en = 1'b0;
        repeat (4) @(negedge clk);
        count_hi(20, mp, ap, wn);
        chk("R6 disabled again", mp + ap + wn + int'(ref_tick), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule